// File: doc/BRIEF.md
# Single-Wire Gauge Bus Master

This block is a memory-mapped master for a single-wire, half-duplex bus of the kind used by battery fuel gauges. Software talks to it through a plain 32-bit read/write strobe port. It loads a byte to send and then writes the control register to start one of three operations. A break pulse wakes and resynchronises the slave. A byte write shifts the loaded byte onto the line. A byte read measures the slave's pulses and assembles one byte.

The line is open-drain: the block either pulls it low or lets it float, and it samples the wire through a synchroniser. All line timing is expressed in ticks of `CLK_DIV` clock cycles, so one set of tick counts serves any system clock. Each operation ends by raising its own flag in a clear-on-read status register. The GO bit and the initialisation bit then clear themselves. An interrupt output follows the flags when interrupts are enabled.

A soft reset returns every register to its reset value and shows a done bit when it has finished. A revision register reports a fixed major/minor number.

Top module: `hdqm_top`

## Requirements
- R1: After `rst`, `irq` and `line_drive_low` are 0, control (word 3) and interrupt status (word 4) read 0, and system status (word 6) bit 0 reads 1.
- R2: Word 0 reads `{REV_MAJOR[3:0], REV_MINOR[3:0]}` in bits 7:0; the default is 0x12.
- R3: A control write with bit 4 (GO) = 1, bit 5 (clock enable) = 1, bit 2 = 0 and bit 1 (direction) = 0 shifts out the byte in word 1, LSB first, one bit per slot of `SLOT_T` ticks. A 1 is a low pulse of exactly `ONE_T*CLK_DIV` cycles and a 0 is a low pulse of exactly `ZERO_T*CLK_DIV` cycles.
- R4: When a write ends, interrupt-status bit 2 is set alone and GO (control bit 4) reads 0.
- R5: GO with direction = 1 receives a byte LSB first. A slave low pulse shorter than `RX_THR_T*CLK_DIV` cycles is a 1, and a longer one is a 0. At the end the byte is in word 2, interrupt-status bit 1 is set alone, and GO clears.
- R6: During a read, if no falling edge arrives within `RX_WIN_T*CLK_DIV` cycles, the read aborts: interrupt-status bit 0 is set alone and GO clears.
- R7: GO with bit 2 (initialisation) = 1 drives the line low for exactly `BRK_LOW_T*CLK_DIV` cycles and then releases it for `BRK_REC_T` ticks. It then sets interrupt-status bit 0, and bits 2 and 4 of control clear.
- R8: A read of word 4 returns the flags and leaves them at 0, so a second read returns 0.
- R9: `irq` is 1 exactly while control bit 6 (interrupt enable) is 1 and any flag is set. It rises only after an operation ends or after a control write.
- R10: A GO written with clock enable = 0 is ignored: the line stays released and GO reads 0.
- R11: Writing word 5 with bit 1 = 1 starts a soft reset. System-status bit 0 reads 0 for `RST_CYC` cycles and then 1, and every register returns to its reset value. Word 5 bit 0 is a plain stored flag that reads back.
- R12: The line is released whenever no operation is running and in the cycle an operation ends.
- R13: A GO written while an operation runs is ignored. The running operation finishes unchanged and only its own flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address; bits 1:0 must be 0 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt request |
| line_in | input | 1 | Sampled level of the bus wire |
| line_drive_low | output | 1 | 1 pulls the wire low, 0 releases it |

## Verification
Register data appears on `rdata` one clock after the read strobe. The bench therefore raises the strobe on a falling edge and takes the data on the next falling edge.

An accepted GO produces the start pulse one cycle after the write. The engine moves one cycle later. A flag and `irq` appear one cycle after the engine's end event. Because a whole operation lasts hundreds of cycles, the bench does not predict its end cycle. It polls GO and only then checks flags and data.

Line pulse widths are counted cycle by cycle at falling edges and compared exactly against the tick counts times `CLK_DIV`. The soft-reset done bit is read in the cycle right after the reset write, and again well after `RST_CYC`.

// File: rtl/hdqm_pkg.sv
package hdqm_pkg;

  typedef enum logic [1:0] {
    OP_BRK,
    OP_WR,
    OP_RD
  } hdq_op_e;

  typedef enum logic [2:0] {
    E_IDLE,
    E_BRK_LOW,
    E_BRK_REC,
    E_TX_LOW,
    E_TX_REL,
    E_RX_WAIT,
    E_RX_LOW
  } eng_st_e;

  // word indices (byte offset / 4)
  localparam int W_REV  = 0;
  localparam int W_TX   = 1;
  localparam int W_RX   = 2;
  localparam int W_CTRL = 3;
  localparam int W_INT  = 4;
  localparam int W_SCFG = 5;
  localparam int W_SSTA = 6;

  // control bit positions
  localparam int CB_MODE  = 0;
  localparam int CB_DIR   = 1;
  localparam int CB_INIT  = 2;
  localparam int CB_GO    = 4;
  localparam int CB_CLKEN = 5;
  localparam int CB_IE    = 6;

  // system configuration bit positions
  localparam int SB_IDLE = 0;
  localparam int SB_SRST = 1;

endpackage

// File: rtl/hdqm_regs.sv
module hdqm_regs
  import hdqm_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int REV_MAJOR = 1,
  parameter int REV_MINOR = 2,
  parameter int RST_CYC   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              start,
  output hdq_op_e           op,
  output logic [7:0]        tx_byte,
  output logic              srst_busy,
  input  logic              evt_tx,
  input  logic              evt_rx,
  input  logic              evt_to,
  input  logic [7:0]        rx_byte
);

  localparam int WI_W = ADDR_W - 2;
  localparam int RC_W = $clog2(RST_CYC + 1);

  logic [WI_W-1:0] widx;
  logic            aligned;
  logic [RC_W-1:0] srst_cnt;
  logic            srst_act, srst_wr, wr_ctrl, go_ok, rd_int, evt_any;
  logic            mode_q, dir_q, init_q, go_q, clken_q, ie_q, idle_q;
  logic [2:0]      flags_q, flags_d;
  logic            ie_d;
  logic [7:0]      rx_q;
  logic            unused_bits;

  assign widx        = addr[ADDR_W-1:2];
  assign aligned     = (addr[1:0] == 2'b00);
  assign srst_act    = (srst_cnt != '0);
  assign srst_busy   = srst_act;
  assign evt_any     = evt_tx | evt_rx | evt_to;
  assign unused_bits = ^{wdata[31:8], wdata[3]};

  always_comb begin
    srst_wr = wr_en && aligned && !srst_act && (widx == WI_W'(W_SCFG)) && wdata[SB_SRST];
    wr_ctrl = wr_en && aligned && !srst_act && (widx == WI_W'(W_CTRL));
    go_ok   = wr_ctrl && !go_q && wdata[CB_GO] && wdata[CB_CLKEN];
    rd_int  = rd_en && aligned && (widx == WI_W'(W_INT));
    if (srst_act || srst_wr) begin
      flags_d = '0;
      ie_d    = 1'b0;
    end else begin
      flags_d = (rd_int ? 3'b000 : flags_q) | {evt_tx, evt_rx, evt_to};
      ie_d    = wr_ctrl ? wdata[CB_IE] : ie_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srst_cnt <= '0;
      mode_q   <= 1'b0;
      dir_q    <= 1'b0;
      init_q   <= 1'b0;
      go_q     <= 1'b0;
      clken_q  <= 1'b0;
      ie_q     <= 1'b0;
      idle_q   <= 1'b0;
      flags_q  <= '0;
      irq      <= 1'b0;
      start    <= 1'b0;
      op       <= OP_WR;
      tx_byte  <= '0;
      rx_q     <= '0;
      rdata    <= '0;
    end else begin
      start   <= go_ok;
      flags_q <= flags_d;
      ie_q    <= ie_d;
      irq     <= ie_d & (|flags_d);

      if (srst_wr)       srst_cnt <= RC_W'(RST_CYC);
      else if (srst_act) srst_cnt <= srst_cnt - 1'b1;

      if (srst_wr || srst_act) begin
        mode_q  <= 1'b0;
        dir_q   <= 1'b0;
        init_q  <= 1'b0;
        go_q    <= 1'b0;
        clken_q <= 1'b0;
        idle_q  <= 1'b0;
        tx_byte <= '0;
        rx_q    <= '0;
      end else begin
        if (wr_en && aligned && widx == WI_W'(W_SCFG)) idle_q <= wdata[SB_IDLE];
        if (wr_en && aligned && widx == WI_W'(W_TX))   tx_byte <= wdata[7:0];
        if (wr_ctrl) begin
          mode_q  <= wdata[CB_MODE];
          clken_q <= wdata[CB_CLKEN];
          if (!go_q) begin
            dir_q  <= wdata[CB_DIR];
            init_q <= wdata[CB_INIT];
          end
        end
        if (go_ok) begin
          go_q <= 1'b1;
          if (wdata[CB_INIT])     op <= OP_BRK;
          else if (wdata[CB_DIR]) op <= OP_RD;
          else                    op <= OP_WR;
        end
        if (evt_any) begin
          go_q   <= 1'b0;
          init_q <= 1'b0;
        end
        if (evt_rx) rx_q <= rx_byte;
      end

      if (rd_en) begin
        if (!aligned) rdata <= '0;
        else begin
          case (widx)
            WI_W'(W_REV):  rdata <= {24'd0, 4'(REV_MAJOR), 4'(REV_MINOR)};
            WI_W'(W_TX):   rdata <= {24'd0, tx_byte};
            WI_W'(W_RX):   rdata <= {24'd0, rx_q};
            WI_W'(W_CTRL): rdata <= {25'd0, ie_q, clken_q, go_q, 1'b0, init_q, dir_q, mode_q};
            WI_W'(W_INT):  rdata <= {29'd0, flags_q};
            WI_W'(W_SCFG): rdata <= {31'd0, idle_q};
            WI_W'(W_SSTA): rdata <= {31'd0, !srst_act};
            default:       rdata <= '0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/hdqm_engine.sv
module hdqm_engine
  import hdqm_pkg::*;
#(
  parameter int CLK_DIV   = 50,
  parameter int BRK_LOW_T = 190,
  parameter int BRK_REC_T = 40,
  parameter int SLOT_T    = 190,
  parameter int ONE_T     = 40,
  parameter int ZERO_T    = 120,
  parameter int RX_THR_T  = 80,
  parameter int RX_WIN_T  = 320,
  parameter int SYNC_N    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  hdq_op_e    op,
  input  logic [7:0] tx_byte,
  input  logic       line_in,
  output logic       drive_low,
  output logic       busy,
  output logic       evt_tx,
  output logic       evt_rx,
  output logic       evt_to,
  output logic [7:0] rx_byte
);

  localparam int BRK_LOW_C = BRK_LOW_T * CLK_DIV;
  localparam int BRK_REC_C = BRK_REC_T * CLK_DIV;
  localparam int SLOT_C    = SLOT_T * CLK_DIV;
  localparam int ONE_C     = ONE_T * CLK_DIV;
  localparam int ZERO_C    = ZERO_T * CLK_DIV;
  localparam int RX_THR_C  = RX_THR_T * CLK_DIV;
  localparam int RX_WIN_C  = RX_WIN_T * CLK_DIV;
  localparam int TOP_C = (BRK_LOW_C > SLOT_C) ?
                         ((BRK_LOW_C > RX_WIN_C) ? BRK_LOW_C : RX_WIN_C) :
                         ((SLOT_C > RX_WIN_C) ? SLOT_C : RX_WIN_C);
  localparam int TMR_W = $clog2(TOP_C + 1);

  eng_st_e           st;
  logic [TMR_W-1:0]  tmr;
  logic [2:0]        bitn;
  logic [7:0]        shreg;
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q, line_s, fall, rx_bit;
  logic [7:0]        rx_next;

  function automatic logic [TMR_W-1:0] low_ld(input logic b);
    return b ? TMR_W'(ONE_C - 1) : TMR_W'(ZERO_C - 1);
  endfunction

  function automatic logic [TMR_W-1:0] rel_ld(input logic b);
    return b ? TMR_W'(SLOT_C - ONE_C - 1) : TMR_W'(SLOT_C - ZERO_C - 1);
  endfunction

  assign line_s = sync_q[SYNC_N-1];
  assign busy   = (st != E_IDLE);

  always_comb begin
    fall    = prev_q & ~line_s;
    rx_bit  = (tmr < TMR_W'(RX_THR_C));
    rx_next = {rx_bit, shreg[7:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= E_IDLE;
      tmr       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      sync_q    <= '1;
      prev_q    <= 1'b1;
      drive_low <= 1'b0;
      evt_tx    <= 1'b0;
      evt_rx    <= 1'b0;
      evt_to    <= 1'b0;
      rx_byte   <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], line_in};
      prev_q <= line_s;
      evt_tx <= 1'b0;
      evt_rx <= 1'b0;
      evt_to <= 1'b0;
      case (st)
        E_IDLE: if (start) begin
          bitn <= '0;
          case (op)
            OP_BRK: begin
              st        <= E_BRK_LOW;
              tmr       <= TMR_W'(BRK_LOW_C - 1);
              drive_low <= 1'b1;
            end
            OP_WR: begin
              st        <= E_TX_LOW;
              shreg     <= tx_byte;
              tmr       <= low_ld(tx_byte[0]);
              drive_low <= 1'b1;
            end
            default: begin
              st  <= E_RX_WAIT;
              tmr <= TMR_W'(RX_WIN_C - 1);
            end
          endcase
        end
        E_BRK_LOW: begin
          if (tmr == '0) begin
            st        <= E_BRK_REC;
            tmr       <= TMR_W'(BRK_REC_C - 1);
            drive_low <= 1'b0;
          end else tmr <= tmr - 1'b1;
        end
        E_BRK_REC: begin
          if (tmr == '0) begin
            st     <= E_IDLE;
            evt_to <= 1'b1;
          end else tmr <= tmr - 1'b1;
        end
        E_TX_LOW: begin
          if (tmr == '0) begin
            st        <= E_TX_REL;
            tmr       <= rel_ld(shreg[0]);
            drive_low <= 1'b0;
          end else tmr <= tmr - 1'b1;
        end
        E_TX_REL: begin
          if (tmr == '0) begin
            if (bitn == 3'd7) begin
              st     <= E_IDLE;
              evt_tx <= 1'b1;
            end else begin
              bitn      <= bitn + 1'b1;
              shreg     <= {1'b0, shreg[7:1]};
              st        <= E_TX_LOW;
              tmr       <= low_ld(shreg[1]);
              drive_low <= 1'b1;
            end
          end else tmr <= tmr - 1'b1;
        end
        E_RX_WAIT: begin
          if (fall) begin
            st  <= E_RX_LOW;
            tmr <= TMR_W'(1);
          end else if (tmr == '0) begin
            st     <= E_IDLE;
            evt_to <= 1'b1;
          end else tmr <= tmr - 1'b1;
        end
        E_RX_LOW: begin
          if (line_s) begin
            shreg <= rx_next;
            if (bitn == 3'd7) begin
              st      <= E_IDLE;
              evt_rx  <= 1'b1;
              rx_byte <= rx_next;
            end else begin
              bitn <= bitn + 1'b1;
              st   <= E_RX_WAIT;
              tmr  <= TMR_W'(RX_WIN_C - 1);
            end
          end else if (tmr == TMR_W'(RX_WIN_C)) begin
            st     <= E_IDLE;
            evt_to <= 1'b1;
          end else tmr <= tmr + 1'b1;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hdqm_top.sv
module hdqm_top
  import hdqm_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int REV_MAJOR = 1,
  parameter int REV_MINOR = 2,
  parameter int RST_CYC   = 8,
  parameter int CLK_DIV   = 50,
  parameter int BRK_LOW_T = 190,
  parameter int BRK_REC_T = 40,
  parameter int SLOT_T    = 190,
  parameter int ONE_T     = 40,
  parameter int ZERO_T    = 120,
  parameter int RX_THR_T  = 80,
  parameter int RX_WIN_T  = 320,
  parameter int SYNC_N    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  input  logic              line_in,
  output logic              line_drive_low
);

  logic       eng_start, eng_busy, eng_rst, srst_busy;
  logic       evt_tx, evt_rx, evt_to;
  hdq_op_e    eng_op;
  logic [7:0] tx_byte, rx_byte;

  assign eng_rst = rst | srst_busy;

  hdqm_regs #(
    .ADDR_W(ADDR_W), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR), .RST_CYC(RST_CYC)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .start(eng_start), .op(eng_op), .tx_byte(tx_byte),
    .srst_busy(srst_busy), .evt_tx(evt_tx), .evt_rx(evt_rx), .evt_to(evt_to),
    .rx_byte(rx_byte)
  );

  hdqm_engine #(
    .CLK_DIV(CLK_DIV), .BRK_LOW_T(BRK_LOW_T), .BRK_REC_T(BRK_REC_T), .SLOT_T(SLOT_T),
    .ONE_T(ONE_T), .ZERO_T(ZERO_T), .RX_THR_T(RX_THR_T), .RX_WIN_T(RX_WIN_T),
    .SYNC_N(SYNC_N)
  ) u_eng (
    .clk(clk), .rst(eng_rst), .start(eng_start), .op(eng_op), .tx_byte(tx_byte),
    .line_in(line_in), .drive_low(line_drive_low), .busy(eng_busy),
    .evt_tx(evt_tx), .evt_rx(evt_rx), .evt_to(evt_to), .rx_byte(rx_byte)
  );

endmodule

// File: rtl/hdqm_chk.sv
module hdqm_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic irq,
  input logic drive_low,
  input logic start,
  input logic busy,
  input logic evt_tx,
  input logic evt_rx,
  input logic evt_to
);

  AST_EVT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_tx, evt_rx, evt_to})); // R4

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(evt_tx | evt_rx | evt_to) || $past(wr_en))); // R9

  AST_START_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    start |-> $past(wr_en)); // R10

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy); // R13

  AST_DRIVE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    drive_low |-> busy); // R12

  AST_END_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (evt_tx | evt_rx | evt_to) |-> !drive_low); // R12

endmodule

bind hdqm_top hdqm_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .irq(irq), .drive_low(line_drive_low),
  .start(eng_start), .busy(eng_busy), .evt_tx(evt_tx), .evt_rx(evt_rx), .evt_to(evt_to)
);

// File: tb/tb_hdqm_top.sv
`timescale 1ns/1ps
module tb_hdqm_top;

  localparam int CLK_DIV = 2;
  localparam int BRK_LOW_T = 19, BRK_REC_T = 4, SLOT_T = 19, ONE_T = 4, ZERO_T = 12;
  localparam int RX_THR_T = 8, RX_WIN_T = 40, RST_CYC = 6;
  localparam int ONE_C = ONE_T * CLK_DIV, ZERO_C = ZERO_T * CLK_DIV;
  localparam int BRK_C = BRK_LOW_T * CLK_DIV;

  localparam logic [4:0] A_REV = 5'h00, A_TX = 5'h04, A_RX = 5'h08, A_CTRL = 5'h0C;
  localparam logic [4:0] A_INT = 5'h10, A_SCFG = 5'h14, A_SSTA = 5'h18;

  // {is_read, byte}
  localparam logic [8:0] VEC [6] = '{9'h0A5, 9'h000, 9'h0FF, 9'h13C, 9'h100, 9'h1FF};

  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, line_in, line_drive_low;
  logic        slave_low = 1'b0;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int unsigned lw = 0, last_w = 0, pulses = 0, mon_bits = 0, odd = 0;
  logic [7:0]  mon_byte = '0;
  logic        prev_d = 1'b0;

  assign line_in = ~(line_drive_low | slave_low);

  always #2.5 clk = ~clk;

  hdqm_top #(
    .RST_CYC(RST_CYC), .CLK_DIV(CLK_DIV), .BRK_LOW_T(BRK_LOW_T), .BRK_REC_T(BRK_REC_T),
    .SLOT_T(SLOT_T), .ONE_T(ONE_T), .ZERO_T(ZERO_T), .RX_THR_T(RX_THR_T), .RX_WIN_T(RX_WIN_T)
  ) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .line_in(line_in), .line_drive_low(line_drive_low)
  );

  // line pulse monitor
  always @(negedge clk) begin
    if (line_drive_low) lw++;
    else if (prev_d) begin
      pulses++;
      last_w = lw;
      if (lw == ONE_C) begin mon_byte = {1'b1, mon_byte[7:1]}; mon_bits++; end
      else if (lw == ZERO_C) begin mon_byte = {1'b0, mon_byte[7:1]}; mon_bits++; end
      else odd++;
      lw = 0;
    end
    prev_d = line_drive_low;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements) act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic mon_clr();
    pulses = 0; mon_bits = 0; odd = 0; mon_byte = '0; last_w = 0;
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    int n = 0;
    do begin
      reg_rd(A_CTRL, v);
      n++;
    end while (v[4] && n < 3000);
    chk({req, " GO self-clears"}, {31'd0, v[4]}, 32'd0);
  endtask

  task automatic slave_send(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      repeat (10) @(negedge clk);
      slave_low = 1'b1;
      repeat (b[i] ? 6 : 30) @(negedge clk);
      slave_low = 1'b0;
    end
  endtask

  logic [31:0] v;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 line", {31'd0, line_drive_low}, 32'd0);
    reg_rd(A_CTRL, v); chk("R1 ctrl", v, 32'd0);
    reg_rd(A_INT, v);  chk("R1 int", v, 32'd0);
    reg_rd(A_SSTA, v); chk("R1 sysstatus", v, 32'd1);
    // R2 revision
    reg_rd(A_REV, v);  chk("R2 revision", v, 32'h12);

    // vector table: writes (R3/R4) and reads (R5)
    for (int i = 0; i < 6; i++) begin
      mon_clr();
      if (!VEC[i][8]) begin
        reg_wr(A_TX, {24'd0, VEC[i][7:0]});
        reg_wr(A_CTRL, 32'h70);
        wait_idle("R4");
        chk("R3 byte on line", {24'd0, mon_byte}, {24'd0, VEC[i][7:0]});
        chk("R3 bit count", mon_bits, 8);
        chk("R3 odd widths", odd, 0);
        chk("R9 irq after write", {31'd0, irq}, 32'd1);
        reg_rd(A_INT, v); chk("R4 tx flag", v, 32'h4);
        reg_rd(A_INT, v); chk("R8 cleared on read", v, 32'h0);
        chk("R9 irq after clear", {31'd0, irq}, 32'd0);
      end else begin
        fork
          slave_send(VEC[i][7:0]);
          reg_wr(A_CTRL, 32'h72);
        join
        wait_idle("R5");
        reg_rd(A_RX, v);  chk("R5 rx byte", v, {24'd0, VEC[i][7:0]});
        reg_rd(A_INT, v); chk("R5 rx flag", v, 32'h2);
        chk("R12 master silent on read", pulses, 0);
      end
      chk("R12 released when idle", {31'd0, line_drive_low}, 32'd0);
    end

    // R6 read timeout
    reg_wr(A_CTRL, 32'h72);
    wait_idle("R6");
    reg_rd(A_INT, v); chk("R6 timeout flag", v, 32'h1);

    // R7 break
    mon_clr();
    reg_wr(A_CTRL, 32'h74);
    wait_idle("R7");
    chk("R7 break width", last_w, BRK_C);
    chk("R7 one pulse", pulses, 1);
    reg_rd(A_INT, v);  chk("R7 timeout flag", v, 32'h1);
    reg_rd(A_CTRL, v); chk("R7 init and go clear", v & 32'h14, 32'h0);

    // R9 interrupt enable gating
    reg_wr(A_TX, 32'h5A);
    reg_wr(A_CTRL, 32'h30);
    wait_idle("R9");
    repeat (2) @(negedge clk);
    chk("R9 irq masked", {31'd0, irq}, 32'd0);
    reg_wr(A_CTRL, 32'h60);
    chk("R9 irq on enable", {31'd0, irq}, 32'd1);
    reg_rd(A_INT, v); chk("R9 pending flag", v, 32'h4);
    chk("R9 irq after read", {31'd0, irq}, 32'd0);

    // R10 GO without clock enable
    mon_clr();
    reg_wr(A_CTRL, 32'h50);
    repeat (60) @(negedge clk);
    chk("R10 no pulses", pulses, 0);
    reg_rd(A_CTRL, v); chk("R10 go reads 0", {31'd0, v[4]}, 32'd0);
    reg_rd(A_INT, v);  chk("R10 no flag", v, 32'h0);

    // R13 GO while busy
    mon_clr();
    reg_wr(A_TX, 32'hA5);
    reg_wr(A_CTRL, 32'h70);
    repeat (20) @(negedge clk);
    reg_wr(A_CTRL, 32'h72);
    wait_idle("R13");
    chk("R13 byte unchanged", {24'd0, mon_byte}, 32'hA5);
    chk("R13 bit count", mon_bits, 8);
    reg_rd(A_INT, v); chk("R13 only tx flag", v, 32'h4);

    // R11 soft reset
    reg_wr(A_CTRL, 32'h60);
    reg_wr(A_SCFG, 32'h1);
    reg_rd(A_SCFG, v); chk("R11 autoidle stored", v, 32'h1);
    reg_wr(A_SCFG, 32'h2);
    reg_rd(A_SSTA, v); chk("R11 done low", v, 32'h0);
    repeat (20) @(negedge clk);
    reg_rd(A_SSTA, v); chk("R11 done high", v, 32'h1);
    reg_rd(A_CTRL, v); chk("R11 ctrl reset", v, 32'h0);
    reg_rd(A_SCFG, v); chk("R11 scfg reset", v, 32'h0);
    reg_rd(A_TX, v);   chk("R11 tx reset", v, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule